// File: doc/BRIEF.md
# SDRAM Bank State Command Tracker

This block sits between a memory client and the command pins of a four-bank SDRAM. Each cycle the client offers one command (activate, read, write, precharge, burst stop or nothing) with a bank number and an A10 bit. The block keeps the state of every bank: idle, holding an open row, or closing with a row-precharge countdown. A legal command is driven one cycle later on the chip-select, row-strobe, column-strobe and write-enable lines, together with the bank address and A10. An illegal command is dropped: the lines carry a no-operation instead, and an error flag is raised for that cycle.

The block also follows the most recent read or write burst. When that access asked for auto-precharge, the block closes the bank on its own when the burst ends. The bank then stays blocked for the precharge time, counted from that cycle. A burst stop, or a newer read or write that cuts the burst short, starts the closing early. For full-page bursts the auto-precharge request is ignored.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Client command codes on `cmd_i` are 0 nothing, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop; 6 and 7 count as nothing. An accepted command appears on the register after the sampling edge as {cs_n,ras_n,cas_n,we_n}: activate 0011, read 0101, write 0100, precharge 0010, burst stop 0110. Every other cycle, including reset, drives the no-operation 0111 with `ba_o` and `a10_o` at 0.
- R2: A read or write to a bank that has no open row is rejected. The output shows 0111 and `err_o` is 1 for that cycle, and no bank state changes.
- R3: After a bank begins closing on edge k, an activate to it is rejected on edges before k+T_RP and accepted on edge k+T_RP.
- R4: A precharge with A10 low closes only the bank on `bank_i`. Open rows in the other banks stay usable.
- R5: A precharge with A10 high closes every open bank and drives `a10_o` high.
- R6: Burst length comes from `bl_sel_i` when the read or write is accepted: codes 0 to 3 give 1, 2, 4 and 8 beats. A read or write accepted on edge k with A10 high and length N closes its bank on edge k+N, so the next activate to it is first accepted on edge k+N+T_RP.
- R7: Auto-precharge applies to one access only. A later read or write with A10 low leaves the row open.
- R8: Codes 4 to 7 on `bl_sel_i` select a full-page burst. Such a burst never ends by itself, and a request for auto-precharge on it is ignored, even after a burst stop.
- R9: A burst stop accepted on edge k while a fixed-length auto-precharge burst runs closes that bank on edge k.
- R10: While an auto-precharge burst is pending, a read or write to the same bank is rejected. A read or write to another bank, accepted on edge k, closes the pending bank on edge k.
- R11: An activate to a bank whose row is already open is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Client command code |
| bank_i | input | 2 | Target bank |
| a10_i | input | 1 | A10: all-banks for precharge, auto-precharge for read/write |
| bl_sel_i | input | 3 | Burst length code for read/write |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address driven with the command |
| a10_o | output | 1 | A10 driven with the command |
| err_o | output | 1 | One-cycle flag for a rejected command |

## Verification
Bank state cannot be seen at the ports, so the bench learns it from outcomes. After each closing event it repeats an activate every cycle and counts the cycles until one is accepted. Rejected activates change nothing, so this count measures the closing edge directly. The hardest case is an auto-precharge cut short by a newer access. To reach it, the bench starts an eight-beat auto-precharge read, then on the next cycle sends a read to the same bank, which must be rejected. It follows with a read to another bank and checks that the countdown dates from that edge.

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int T_RP  = 3,
  parameter int BANKS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 cmd_i,
  input  logic [$clog2(BANKS)-1:0]   bank_i,
  input  logic                       a10_i,
  input  logic [2:0]                 bl_sel_i,
  output logic                       cs_n_o,
  output logic                       ras_n_o,
  output logic                       cas_n_o,
  output logic                       we_n_o,
  output logic [$clog2(BANKS)-1:0]   ba_o,
  output logic                       a10_o,
  output logic                       err_o
);
  localparam int BW = $clog2(BANKS);
  localparam int CW = (T_RP < 2) ? 1 : $clog2(T_RP);
  localparam logic [1:0] S_IDLE = 2'd0, S_OPEN = 2'd1, S_CLOSE = 2'd2;
  localparam logic [CW-1:0] CNT_LOAD = CW'(T_RP - 1);

  logic [1:0]    st_q  [BANKS];
  logic [CW-1:0] cnt_q [BANKS];

  logic          bu_act, bu_ap, bu_full;
  logic [BW-1:0] bu_bank;
  logic [3:0]    bu_rem;

  wire is_act = cmd_i == 3'd1;
  wire is_rw  = cmd_i == 3'd2 || cmd_i == 3'd3;
  wire is_pre = cmd_i == 3'd4;
  wire is_bst = cmd_i == 3'd5;

  wire [1:0] sel_st  = st_q[bank_i];
  wire       ap_hold = bu_act && bu_ap && bu_bank == bank_i;
  wire       bad     = (is_act && sel_st != S_IDLE) ||
                       (is_rw && (sel_st != S_OPEN || ap_hold));
  wire       go      = !bad;
  wire       full_sel = bl_sel_i[2];
  wire [3:0] blen    = 4'd1 << bl_sel_i[1:0];
  wire       nat_end = bu_act && !bu_full && bu_rem == 4'd1;
  wire       pre_hits_burst = go && is_pre && (a10_i || bank_i == bu_bank);
  wire       ap_fire = bu_act && bu_ap && (nat_end || (go && (is_bst || is_rw)));

  logic [BANKS-1:0] open_v, close_v;
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      open_v[b]  = go && is_act && bank_i == BW'(b);
      close_v[b] = (go && is_pre && (a10_i || bank_i == BW'(b)) && st_q[b] == S_OPEN) ||
                   (ap_fire && bu_bank == BW'(b));
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++) begin
      if (!rst_n) begin
        st_q[b]  <= S_IDLE;
        cnt_q[b] <= '0;
      end else if (open_v[b]) begin
        st_q[b]  <= S_OPEN;
      end else if (close_v[b]) begin
        st_q[b]  <= (T_RP <= 1) ? S_IDLE : S_CLOSE;
        cnt_q[b] <= CNT_LOAD;
      end else if (st_q[b] == S_CLOSE) begin
        cnt_q[b] <= cnt_q[b] - 1'b1;
        if (cnt_q[b] == CW'(1)) st_q[b] <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bu_act  <= 1'b0;
      bu_ap   <= 1'b0;
      bu_full <= 1'b0;
      bu_bank <= '0;
      bu_rem  <= '0;
    end else if (go && is_rw) begin
      bu_act  <= 1'b1;
      bu_ap   <= a10_i && !full_sel;
      bu_full <= full_sel;
      bu_bank <= bank_i;
      bu_rem  <= blen;
    end else if (bu_act && (nat_end || (go && is_bst) || pre_hits_burst)) begin
      bu_act  <= 1'b0;
      bu_ap   <= 1'b0;
    end else if (bu_act && !bu_full) begin
      bu_rem  <= bu_rem - 1'b1;
    end
  end

  logic [3:0] pins;
  always_comb begin
    pins = 4'b0111;
    if (go) begin
      case (cmd_i)
        3'd1:    pins = 4'b0011;
        3'd2:    pins = 4'b0101;
        3'd3:    pins = 4'b0100;
        3'd4:    pins = 4'b0010;
        3'd5:    pins = 4'b0110;
        default: pins = 4'b0111;
      endcase
    end
  end

  wire drive_addr = go && (is_act || is_rw || is_pre);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0111;
      ba_o  <= '0;
      a10_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= pins;
      ba_o  <= (drive_addr && !(is_pre && a10_i)) ? bank_i : '0;
      a10_o <= drive_addr ? a10_i : 1'b0;
      err_o <= bad;
    end
  end

  wire out_act = {cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0011;
  wire out_rw  = !cs_n_o && ras_n_o && !cas_n_o;

  assert_err_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> {cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111);

  assert_full_no_ap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bu_full |-> !bu_ap);

  for (genvar g = 0; g < BANKS; g++) begin : g_chk
    assert_act_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_act && ba_o == BW'(g)) |-> $past(st_q[g]) == S_IDLE);
    assert_rw_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_rw && ba_o == BW'(g)) |-> $past(st_q[g]) == S_OPEN);
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CNT_LOAD);
  end
endmodule

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP = 3;

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd_i = 0, bl_sel_i = 0;
  logic [1:0] bank_i = 0;
  logic a10_i = 0;
  logic cs_n_o, ras_n_o, cas_n_o, we_n_o, a10_o, err_o;
  logic [1:0] ba_o;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  sdram_bank_tracker #(.T_RP(T_RP), .BANKS(4)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
    .bl_sel_i(bl_sel_i), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ba_o(ba_o), .a10_o(a10_o), .err_o(err_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic [3:0] pins();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input [2:0] c, input [1:0] b, input a, input [2:0] bl);
    cmd_i = c; bank_i = b; a10_i = a; bl_sel_i = bl;
    @(negedge clk);
    cmd_i = 0; bank_i = 0; a10_i = 0; bl_sel_i = 0;
  endtask

  task automatic probe(input [1:0] b, output int m);
    m = 0;
    for (int i = 1; i <= 40; i++) begin
      step(3'd1, b, 0, 0);
      if (!err_o) begin m = i; break; end
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int m;
    repeat (3) @(negedge clk);
    chk(pins() == 4'b0111 && err_o == 0 && ba_o == 0 && a10_o == 0, "R1 reset", pins(), 4'b0111);
    rst_n = 1;

    step(3'd2, 0, 0, 0);
    chk(err_o && pins() == 4'b0111, "R2 read idle", {err_o, pins()}, 5'b10111);
    step(3'd3, 3, 0, 0);
    chk(err_o && pins() == 4'b0111, "R2 write idle", {err_o, pins()}, 5'b10111);
    step(3'd6, 1, 0, 0);
    chk(!err_o && pins() == 4'b0111, "R1 code 6 nothing", {err_o, pins()}, 5'b00111);

    for (int b = 0; b < 4; b++) begin
      step(3'd1, 2'(b), 0, 0);
      chk(!err_o && pins() == 4'b0011 && ba_o == 2'(b), "R1 activate", {pins(), ba_o}, {4'b0011, 2'(b)});
    end
    step(3'd1, 0, 0, 0);
    chk(err_o, "R11 activate open bank", err_o, 1);

    for (int b = 0; b < 4; b++) begin
      step(3'd4, 2'(b), 0, 0);
      chk(pins() == 4'b0010 && ba_o == 2'(b) && !a10_o, "R1 precharge", {pins(), ba_o}, {4'b0010, 2'(b)});
      probe(2'(b), m);
      chk(m == T_RP, "R3 precharge window", m, T_RP);
    end

    step(3'd4, 2, 0, 0);
    for (int b = 0; b < 4; b++) begin
      if (b == 2) continue;
      step(3'd2, 2'(b), 0, 0);
      chk(!err_o && pins() == 4'b0101 && ba_o == 2'(b), "R4 other bank open", {err_o, pins()}, 5'b00101);
    end
    step(3'd2, 2, 0, 0);
    chk(err_o, "R4 selected bank closed", err_o, 1);
    probe(2, m);

    step(3'd4, 1, 1, 0);
    chk(pins() == 4'b0010 && a10_o, "R5 all-bank precharge pins", {pins(), a10_o}, 5'b00101);
    probe(0, m);
    chk(m == T_RP, "R5 bank0 window", m, T_RP);
    for (int b = 1; b < 4; b++) begin
      step(3'd1, 2'(b), 0, 0);
      chk(!err_o, "R5 bank closed by all", err_o, 0);
    end

    for (int rw = 0; rw < 2; rw++)
      for (int bl = 0; bl < 4; bl++)
        for (int b = 0; b < 4; b++) begin
          step(rw ? 3'd3 : 3'd2, 2'(b), 1, 3'(bl));
          chk(!err_o && pins() == (rw ? 4'b0100 : 4'b0101) && a10_o,
              "R1 read/write pins", pins(), rw ? 4'b0100 : 4'b0101);
          probe(2'(b), m);
          chk(m == (1 << bl) + T_RP, "R6 auto-precharge window", m, (1 << bl) + T_RP);
        end

    step(3'd2, 0, 1, 0);
    probe(0, m);
    step(3'd2, 0, 0, 0);
    repeat (10) step(3'd0, 0, 0, 0);
    step(3'd2, 0, 0, 0);
    chk(!err_o, "R7 row stays open", err_o, 0);
    step(3'd1, 0, 0, 0);
    chk(err_o, "R7 no hidden precharge", err_o, 1);

    step(3'd2, 1, 1, 3'd7);
    chk(!err_o, "R8 full-page read", err_o, 0);
    repeat (20) step(3'd0, 0, 0, 0);
    step(3'd1, 1, 0, 0);
    chk(err_o, "R8 full page still open", err_o, 1);
    step(3'd5, 0, 0, 0);
    chk(pins() == 4'b0110, "R1 burst stop pins", pins(), 4'b0110);
    repeat (T_RP + 2) step(3'd0, 0, 0, 0);
    step(3'd1, 1, 0, 0);
    chk(err_o, "R8 no close after stop", err_o, 1);
    step(3'd2, 1, 0, 0);
    chk(!err_o, "R8 row usable", err_o, 0);

    step(3'd2, 2, 1, 3'd3);
    step(3'd0, 0, 0, 0);
    step(3'd5, 0, 0, 0);
    probe(2, m);
    chk(m == T_RP, "R9 stop starts close", m, T_RP);

    step(3'd2, 0, 1, 3'd3);
    step(3'd2, 0, 0, 0);
    chk(err_o, "R10 same bank pending", err_o, 1);
    step(3'd2, 1, 0, 0);
    chk(!err_o, "R10 other bank read", err_o, 0);
    probe(0, m);
    chk(m == T_RP, "R10 interrupt close", m, T_RP);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule